// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block holds a small set of independent countdown channels behind a word-addressed register port. Software loads a 64-bit interval into a channel and then writes a control word. That word enables the channel, asks for the interval to be copied into the counter, chooses a power-of-two prescale and chooses one-shot or periodic behaviour. On each prescaled tick the counter steps down by one. When it runs out, the channel raises its pending flag. A periodic channel then refills itself and keeps going. A one-shot channel parks at zero and turns itself off.

The pending flags share a status word and are cleared by writing ones to it. A separate enable word masks which flags reach the single interrupt line. A channel that is stopped by software keeps counting for two more counter ticks before it halts, so software has to wait that long before it relies on the value. A periodic channel loaded with all ones and left running serves as a time base that wraps forever. The register read data is a combinational function of the address. The read strobe matters only for the count-high shadow.

Top module: `hst_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: A control write with bit 1 set copies the 64-bit interval into the counter at the next clock edge. From the following cycle on, control bit 1 reads back 0 while the other control fields read back as written.
- R3: Control bits 6:4 hold a prescale value p. After the copy edge E1, the counter drops by one at edges E1+2^p, E1+2*2^p, and so on. Reads of the count-low and count-high registers (window offsets 0x0C and 0x10) show a falling value.
- R4: With control bit 7 at 0 (periodic), a tick that finds the count at 1 or 0 reloads the interval and sets the channel's status bit, so one period lasts N ticks for an interval N.
- R5: With control bit 7 at 1 (one-shot), that same tick sets the status bit, leaves the count at 0 and clears control bit 0. The count then stays at 0.
- R6: A control write that clears bit 0 on a running channel reads back as disabled at once. The counter still takes its tick at that edge and exactly two more counter ticks, then holds.
- R7: Writing the status word (offset 0x04) with a 1 in bit n clears channel n's pending flag. A 0 in a bit leaves that flag as it was.
- R8: `irq` is high exactly when some channel has both its status bit and its enable bit (offset 0x00, bit n for channel n) set.
- R9: Reading count-low latches the counter's upper 32 bits. The next count-high read returns that latched value, even if the live counter has since moved.
- R10: Writes to the count registers have no effect. Reads of addresses outside the map, or of unaligned addresses, return 0.
- R11: A status bit is set when its channel expires even when that channel's enable bit is 0, and in that case `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe, taken at the rising edge |
| reg_rd | input | 1 | Read strobe; latches the count-high shadow on a count-low read |
| reg_addr | input | ADDR_W | Byte address. Enable 0x00, status 0x04, channel n window at 0x10+0x20n: control, interval low, interval high, count low, count high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Combined interrupt |

## Verification
The random vectors mix the channel, the prescale from 1 to 8, the mode, short intervals that wrap within the window and long intervals with a non-zero upper word. They also vary the time waited before the count is read. Short intervals tell apart an off-by-one in the wrap point and a mode mix-up. Longer waits under prescale catch a divider that starts out of phase. The directed cases drive the features that random timing would rarely hit in isolation: a disable that lands mid-run, and a shadow read taken just as the upper word rolls over. They also cover a write-one-to-clear set against a write of zero, and an expiry that is masked from the interrupt.

// File: rtl/hst_pkg.sv
package hst_pkg;

    localparam int DATA_W      = 32;
    localparam int CNT_W       = 2 * DATA_W;
    localparam int PSC_W       = 3;
    localparam int DRAIN_TICKS = 2;
    localparam int DRAIN_W     = 2;
    localparam int ADDR_IEN    = 'h00;
    localparam int ADDR_IST    = 'h04;
    localparam int WIN_BASE    = 'h10;
    localparam int WIN_SHIFT   = 5;

    typedef struct packed {
        logic             oneshot;
        logic [PSC_W-1:0] psc;
        logic             reload;
        logic             en;
    } ctrl_t;

    typedef enum logic [2:0] {
        FLD_CTRL   = 3'd0,
        FLD_IVL_LO = 3'd1,
        FLD_IVL_HI = 3'd2,
        FLD_CNT_LO = 3'd3,
        FLD_CNT_HI = 3'd4,
        FLD_NONE   = 3'd7
    } fld_e;

    typedef struct packed {
        logic       ien;
        logic       ist;
        logic       win;
        logic [7:0] ch;
        fld_e       fld;
    } regsel_t;

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.en      = w[0];
        c.reload  = w[1];
        c.psc     = w[6:4];
        c.oneshot = w[7];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
        return {24'd0, c.oneshot, c.psc, 2'b00, c.reload, c.en};
    endfunction

    function automatic regsel_t reg_decode(input logic [31:0] a, input int unsigned nch);
        regsel_t     s;
        logic [31:0] off;
        s     = '0;
        s.fld = FLD_NONE;
        off   = a - 32'(WIN_BASE);
        if (a[1:0] == 2'b00) begin
            if (a == 32'(ADDR_IEN)) begin
                s.ien = 1'b1;
            end else if (a == 32'(ADDR_IST)) begin
                s.ist = 1'b1;
            end else if (a >= 32'(WIN_BASE) && (off >> WIN_SHIFT) < nch && off[4:2] <= 3'd4) begin
                s.win = 1'b1;
                s.ch  = 8'(off >> WIN_SHIFT);
                s.fld = fld_e'(off[4:2]);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/hst_prescale.sv
module hst_prescale
    import hst_pkg::*;
#(
    parameter int SEL_W = PSC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [SEL_W-1:0] psc,
    output logic             tick
);

    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_r;
    logic [DIV_W-1:0] mask;

    assign mask = ~({DIV_W{1'b1}} << psc);
    assign tick = run && ((div_r & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_r <= '0;
        end else if (run) begin
            div_r <= div_r + 1'b1;
        end
    end

endmodule

// File: rtl/hst_channel.sv
module hst_channel
    import hst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic              ivl_lo_we,
    input  logic              ivl_hi_we,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  ivl_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              fire
);

    ctrl_t              ctrl_r;
    ctrl_t              wctl;
    logic [CNT_W-1:0]   ivl_r;
    logic [CNT_W-1:0]   cnt_r;
    logic [DRAIN_W-1:0] drain_r;
    logic               active;
    logic               run;
    logic               tick;

    assign wctl   = ctrl_unpack(wdata);
    assign active = ctrl_r.en || (drain_r != '0);
    assign run    = active && !ctrl_r.reload;
    assign fire   = tick && (cnt_r <= CNT_W'(1));

    hst_prescale #(.SEL_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .restart (ctrl_r.reload),
        .run     (run),
        .psc     (ctrl_r.psc),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_r  <= '0;
            ivl_r   <= '0;
            cnt_r   <= '0;
            drain_r <= '0;
        end else begin
            if (ivl_lo_we) ivl_r[DATA_W-1:0]     <= wdata;
            if (ivl_hi_we) ivl_r[CNT_W-1:DATA_W] <= wdata;

            if (ctrl_we) begin
                ctrl_r <= wctl;
            end else begin
                ctrl_r.reload <= 1'b0;
                if (fire && ctrl_r.oneshot) ctrl_r.en <= 1'b0;
            end

            if (ctrl_r.reload) begin
                cnt_r <= ivl_r;
            end else if (fire) begin
                cnt_r <= ctrl_r.oneshot ? '0 : ivl_r;
            end else if (tick) begin
                cnt_r <= cnt_r - 1'b1;
            end

            if (ctrl_we) begin
                drain_r <= (ctrl_r.en && !wctl.en) ? DRAIN_W'(DRAIN_TICKS) : '0;
            end else if (fire && ctrl_r.oneshot) begin
                drain_r <= '0;
            end else if (tick && drain_r != '0) begin
                drain_r <= drain_r - 1'b1;
            end
        end
    end

    assign ctrl_q = ctrl_r;
    assign ivl_q  = ivl_r;
    assign cnt_q  = cnt_r;

    a_r2_reload_copy: assert property (@(posedge clk) disable iff (rst)
        ctrl_r.reload |=> cnt_r == $past(ivl_r));

    a_r4_periodic_wrap: assert property (@(posedge clk) disable iff (rst)
        (fire && !ctrl_r.oneshot) |=> cnt_r == $past(ivl_r));

    a_r5_oneshot_halt: assert property (@(posedge clk) disable iff (rst)
        (fire && ctrl_r.oneshot && !ctrl_we) |=> (!ctrl_r.en && cnt_r == '0));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!active && !ctrl_r.reload) |=> $stable(cnt_r));

endmodule

// File: rtl/hst_rdmux.sv
module hst_rdmux
    import hst_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  regsel_t                         sel,
    input  logic [NUM_CH-1:0]               ien,
    input  logic [NUM_CH-1:0]               st,
    input  logic [NUM_CH-1:0][DATA_W-1:0]   ctl_w,
    input  logic [NUM_CH-1:0][DATA_W-1:0]   ivl_lo,
    input  logic [NUM_CH-1:0][DATA_W-1:0]   ivl_hi,
    input  logic [NUM_CH-1:0][DATA_W-1:0]   cnt_lo,
    input  logic [NUM_CH-1:0][DATA_W-1:0]   shd_hi,
    output logic [DATA_W-1:0]               rdata
);

    always_comb begin
        rdata = '0;
        if (sel.ien) rdata = DATA_W'(ien);
        if (sel.ist) rdata = DATA_W'(st);
        if (sel.win) begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (sel.ch == 8'(n)) begin
                    case (sel.fld)
                        FLD_CTRL:   rdata = ctl_w[n];
                        FLD_IVL_LO: rdata = ivl_lo[n];
                        FLD_IVL_HI: rdata = ivl_hi[n];
                        FLD_CNT_LO: rdata = cnt_lo[n];
                        FLD_CNT_HI: rdata = shd_hi[n];
                        default:    rdata = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/hst_timer.sv
module hst_timer
    import hst_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);

    regsel_t                       sel;
    logic [NUM_CH-1:0]             ien_r;
    logic [NUM_CH-1:0]             st_r;
    logic [NUM_CH-1:0]             fire_v;
    logic [NUM_CH-1:0][DATA_W-1:0] ctl_w;
    logic [NUM_CH-1:0][DATA_W-1:0] ivl_lo;
    logic [NUM_CH-1:0][DATA_W-1:0] ivl_hi;
    logic [NUM_CH-1:0][DATA_W-1:0] cnt_lo;
    logic [NUM_CH-1:0][DATA_W-1:0] cnt_hi;
    logic [NUM_CH-1:0][DATA_W-1:0] shd_hi;

    assign sel = reg_decode(32'(reg_addr), NUM_CH);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        ctrl_t            c_q;
        logic [CNT_W-1:0] i_q;
        logic [CNT_W-1:0] k_q;
        logic             hit;

        assign hit = reg_wr && sel.win && (sel.ch == 8'(n));

        hst_channel u_ch (
            .clk       (clk),
            .rst       (rst),
            .ctrl_we   (hit && sel.fld == FLD_CTRL),
            .ivl_lo_we (hit && sel.fld == FLD_IVL_LO),
            .ivl_hi_we (hit && sel.fld == FLD_IVL_HI),
            .wdata     (reg_wdata),
            .ctrl_q    (c_q),
            .ivl_q     (i_q),
            .cnt_q     (k_q),
            .fire      (fire_v[n])
        );

        assign ctl_w[n]  = ctrl_pack(c_q);
        assign ivl_lo[n] = i_q[DATA_W-1:0];
        assign ivl_hi[n] = i_q[CNT_W-1:DATA_W];
        assign cnt_lo[n] = k_q[DATA_W-1:0];
        assign cnt_hi[n] = k_q[CNT_W-1:DATA_W];

        always_ff @(posedge clk) begin
            if (rst) begin
                shd_hi[n] <= '0;
            end else if (reg_rd && sel.win && sel.ch == 8'(n) && sel.fld == FLD_CNT_LO) begin
                shd_hi[n] <= cnt_hi[n];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_r <= '0;
            st_r  <= '0;
        end else begin
            if (reg_wr && sel.ien) ien_r <= reg_wdata[NUM_CH-1:0];
            st_r <= (st_r & ~((reg_wr && sel.ist) ? reg_wdata[NUM_CH-1:0] : '0)) | fire_v;
        end
    end

    assign irq = |(st_r & ien_r);

    hst_rdmux #(.NUM_CH(NUM_CH)) u_rd (
        .sel    (sel),
        .ien    (ien_r),
        .st     (st_r),
        .ctl_w  (ctl_w),
        .ivl_lo (ivl_lo),
        .ivl_hi (ivl_hi),
        .cnt_lo (cnt_lo),
        .shd_hi (shd_hi),
        .rdata  (reg_rdata)
    );

    a_r7_w1c: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && sel.ist) |=>
            ((st_r & $past(reg_wdata[NUM_CH-1:0]) & ~$past(fire_v)) == '0));

    a_r11_expiry_sets: assert property (@(posedge clk) disable iff (rst)
        (fire_v != '0) |=> ((st_r & $past(fire_v)) == $past(fire_v)));

endmodule

// File: tb/test_hst_timer.sv
module test_hst_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hst_timer #(.NUM_CH(2), .ADDR_W(8)) i_hst_timer (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    localparam logic [7:0] A_IEN = 8'h00;
    localparam logic [7:0] A_IST = 8'h04;

    function automatic logic [7:0] a_ctl(input int ch);    return 8'(16 + 32 * ch); endfunction
    function automatic logic [7:0] a_ivlo(input int ch);   return 8'(20 + 32 * ch); endfunction
    function automatic logic [7:0] a_ivhi(input int ch);   return 8'(24 + 32 * ch); endfunction
    function automatic logic [7:0] a_cntlo(input int ch);  return 8'(28 + 32 * ch); endfunction
    function automatic logic [7:0] a_cnthi(input int ch);  return 8'(32 + 32 * ch); endfunction

    // ticks seen c edges after the control write edge with prescale p
    function automatic longint unsigned ticks_after(input int c, input int p);
        return (c >= 1) ? longint'((c - 1) >> p) : 0;
    endfunction

    function automatic longint unsigned exp_count(input longint unsigned n, input longint unsigned k,
                                                  input bit os);
        if (os) return (k >= n) ? 64'd0 : n - k;
        return n - (k % n);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] d, x;
        logic        irq_s;
        int unsigned seed;
        seed = $urandom(32'h5eed);

        idle(3);
        rst = 1'b0;

        // R1 reset state
        rd(A_IEN, d);       chk("R1 ien", d, 0);
        rd(A_IST, d);       chk("R1 status", d, 0);
        rd(a_ctl(0), d);    chk("R1 ctrl0", d, 0);
        rd(a_cntlo(1), d);  chk("R1 cnt1", d, 0);
        chk("R1 irq", irq, 0);

        // R2 / R3 reload with prescale 2
        wr(a_ivlo(0), 7);
        wr(a_ctl(0), 32'h13);
        idle(1);
        rd(a_ctl(0), d);    chk("R2 reload bit reads 0", d, 32'h11);
        rd(a_cntlo(0), d);  chk("R2 interval copied", d, 7);
        rd(a_cntlo(0), d);  chk("R3 first prescaled tick", d, 6);

        // R6 disable drains two ticks
        wr(a_ivlo(0), 1000);
        wr(a_ivhi(0), 0);
        wr(a_ctl(0), 32'h03);
        idle(9);
        wr(a_ctl(0), 32'h00);
        rd(a_ctl(0), d);    chk("R6 enable reads 0", d, 0);
        idle(10);
        rd(a_cntlo(0), d);  chk("R6 two drain ticks", d, 989);
        idle(20);
        rd(a_cntlo(0), d);  chk("R6 holds after drain", d, 989);

        // R9 shadow across upper-word rollover
        wr(a_ivlo(1), 2);
        wr(a_ivhi(1), 1);
        wr(a_ctl(1), 32'h03);
        idle(3);
        rd(a_cntlo(1), d);  chk("R9 low half", d, 0);
        idle(3);
        rd(a_cnthi(1), d);  chk("R9 shadowed high half", d, 1);
        wr(a_ctl(1), 0);
        idle(6);

        // R10 count registers read-only, unmapped reads
        rd(a_cntlo(0), x);
        wr(a_cntlo(0), 32'hDEADBEEF);
        wr(a_cnthi(0), 5);
        rd(a_cntlo(0), d);  chk("R10 count low unchanged", d, x);
        rd(a_cnthi(0), d);  chk("R10 count high unchanged", d, 0);
        rd(8'h08, d);       chk("R10 unmapped", d, 0);
        rd(8'h16, d);       chk("R10 unaligned", d, 0);

        // R11 / R5 / R8 / R7 masked one-shot expiry
        wr(A_IEN, 0);
        wr(A_IST, 3);
        wr(a_ivlo(0), 2);
        wr(a_ctl(0), 32'h83);
        idle(10);
        irq_s = irq;
        rd(A_IST, d);       chk("R11 status set while masked", d, 1);
        chk("R11 irq stays low", irq_s, 0);
        rd(a_ctl(0), d);    chk("R5 one-shot clears enable", d, 32'h80);
        rd(a_cntlo(0), d);  chk("R5 one-shot holds zero", d, 0);
        wr(A_IEN, 1);
        chk("R8 irq on enable", irq, 1);
        wr(A_IST, 0);
        rd(A_IST, d);       chk("R7 zero write keeps flag", d, 1);
        wr(A_IST, 1);
        rd(A_IST, d);       chk("R7 one write clears", d, 0);
        chk("R8 irq drops", irq, 0);

        // random vectors R3 R4 R5 R8 R9
        for (int v = 0; v < 40; v++) begin
            int ch, p, c, ienw;
            bit os;
            logic [31:0] nlo, nhi, lo, hi, st, ctl;
            longint unsigned n, k, e;
            bit fired;
            ch   = $urandom_range(0, 1);
            p    = $urandom_range(0, 3);
            os   = 1'($urandom_range(0, 1));
            c    = $urandom_range(1, 70);
            ienw = $urandom_range(0, 3);
            nlo  = $urandom_range(1, 24);
            nhi  = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 5) : 0;
            n    = {nhi, nlo};
            wr(a_ctl(0), 0);
            wr(a_ctl(1), 0);
            idle(6);
            wr(A_IST, 3);
            wr(A_IEN, 32'(ienw));
            wr(a_ivlo(ch), nlo);
            wr(a_ivhi(ch), nhi);
            wr(a_ctl(ch), {24'd0, os, 3'(p), 4'h3});
            idle(c);
            rd(a_cntlo(ch), lo);
            rd(a_cnthi(ch), hi);
            e = exp_count(n, ticks_after(c, p), os);
            chk(os ? "R5 count" : "R4 count", {hi, lo}, e);
            k     = ticks_after(c + 2, p);
            fired = (k >= n);
            irq_s = irq;
            rd(A_IST, st);
            chk("R11 status", st, fired ? (32'd1 << ch) : 32'd0);
            chk("R8 irq", irq_s, fired && ienw[ch]);
            rd(a_ctl(ch), ctl);
            k = ticks_after(c + 3, p);
            chk("R5 ctrl readback", ctl,
                {24'd0, os, 3'(p), 3'b000, !(os && k >= n)});
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule